// File: doc/BRIEF.md
# H-Bridge Motor Drive Controller

This block is the digital control for one full H-bridge driving a brushed DC motor. An active-high run enable and two direction bits are decoded into gate enables for the high-side and low-side switch of each half-bridge. The supported states are coast (all switches open), forward, reverse and brake (both low sides closed). Every change of a half-bridge state passes through a programmable dead-time, so no leg can ever conduct shoot-through current.

Three protection paths sit between the decoder and the gate stage. An over-current flag replaces an active drive with a slow-decay brake for a fixed hold interval. A per-leg short flag is filtered, and a confirmed short opens only that leg for the same hold interval. The leg is then tried once more. If the short is still present, the whole bridge latches off until the run enable drops. Thermal and undervoltage flags open the bridge for as long as they are present, with no latch. A 3-bit mode output reports which of these states is in force.

Top module: `hbridge_ctrl`

## Requirements
- R1: While `run_en_i` is low, all four gate enables are 0 from the next clock edge, and `mode_o` is 0 (standby), whatever the direction inputs are.
- R2: With `run_en_i` high and no protection active, the direction inputs {`dir_a_i`,`dir_b_i`} select the legs. 00 gives all gates off and mode 1. 10 gives forward: `a_hi_o` and `b_lo_o` on, mode 2. 01 gives reverse: `a_lo_o` and `b_hi_o` on, mode 3. 11 gives brake: `a_lo_o` and `b_lo_o` on, mode 4.
- R3: The high and low enables of one leg are never 1 together. When a leg moves from one driven side to the other, both of its enables stay 0 for at least `DEAD_CYC` cycles.
- R4: An over-current flag seen during forward or reverse drive switches the bridge to both low sides on, with mode 5, for `HOLD_CYC` cycles. Drive then resumes.
- R5: The over-current flag has no effect in the coast or brake states.
- R6: A short flag acts only after it has been high on `DEB_CYC` consecutive clock edges. A shorter pulse leaves outputs and mode unchanged.
- R7: A confirmed short on one leg opens only that leg for `HOLD_CYC` cycles, and the other leg keeps driving. Mode is 6 during this interval and during the retry that follows.
- R8: After the hold interval the leg is driven again. If its short flag is low, normal drive and mode resume.
- R9: If the short flag stays high for `DEB_CYC` edges after the retry starts, all gates go off and mode becomes 7. This state holds against any change of the direction, short or over-current inputs.
- R10: The latched-off state is cleared only by taking `run_en_i` low. Decoded drive then returns when it goes high again.
- R11: A high thermal or undervoltage flag turns all gates off from the next clock edge, with mode 1. Decoded drive resumes after the flag clears, with no latch.
- R12: During and after reset, with `run_en_i` low, all gates are off and mode is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_en_i | input | 1 | Run enable; low selects standby and clears the latch |
| dir_a_i | input | 1 | Direction bit A |
| dir_b_i | input | 1 | Direction bit B |
| ocp_i | input | 1 | Over-current comparator flag |
| short_a_i | input | 1 | Short detected on leg A |
| short_b_i | input | 1 | Short detected on leg B |
| therm_i | input | 1 | Thermal shutdown flag |
| uvlo_i | input | 1 | Supply undervoltage flag |
| a_hi_o | output | 1 | Leg A high-side gate enable |
| a_lo_o | output | 1 | Leg A low-side gate enable |
| b_hi_o | output | 1 | Leg B high-side gate enable |
| b_lo_o | output | 1 | Leg B low-side gate enable |
| mode_o | output | 3 | 0 standby, 1 off, 2 forward, 3 reverse, 4 brake, 5 current limit, 6 short retry, 7 latched fault |

## Verification
The latched fault is the hardest state to reach from the pins. The short flag must survive the debounce, stay asserted through the whole hold interval, and then survive a second debounce that starts only when the retry begins. The bench drives forward, raises one leg's short flag, and holds it for hold plus debounce plus a margin before it samples. It then changes every other input to show that the latch holds, and pulses the run enable to release it. A companion sequence drops the flag during the hold interval to reach the recovery branch instead.

// File: rtl/hb_pkg.sv
package hb_pkg;
  typedef enum logic [1:0] {
    LEG_OFF = 2'd0,
    LEG_HI  = 2'd1,
    LEG_LO  = 2'd2
  } leg_e;

  typedef enum logic [2:0] {
    MD_STBY  = 3'd0,
    MD_OFF   = 3'd1,
    MD_FWD   = 3'd2,
    MD_REV   = 3'd3,
    MD_BRAKE = 3'd4,
    MD_CLIM  = 3'd5,
    MD_SCRTY = 3'd6,
    MD_LATCH = 3'd7
  } mode_e;

  typedef enum logic [2:0] {
    PS_RUN   = 3'd0,
    PS_CLIM  = 3'd1,
    PS_SCWT  = 3'd2,
    PS_SCCHK = 3'd3,
    PS_LATCH = 3'd4
  } pstate_e;
endpackage

// File: rtl/hb_decode.sv
module hb_decode
  import hb_pkg::*;
(
  input  logic  dir_a_i,
  input  logic  dir_b_i,
  output leg_e  leg_a_o,
  output leg_e  leg_b_o,
  output mode_e mode_o,
  output logic  drive_o
);
  always_comb begin
    unique case ({dir_a_i, dir_b_i})
      2'b10:   begin leg_a_o = LEG_HI;  leg_b_o = LEG_LO;  mode_o = MD_FWD;   end
      2'b01:   begin leg_a_o = LEG_LO;  leg_b_o = LEG_HI;  mode_o = MD_REV;   end
      2'b11:   begin leg_a_o = LEG_LO;  leg_b_o = LEG_LO;  mode_o = MD_BRAKE; end
      default: begin leg_a_o = LEG_OFF; leg_b_o = LEG_OFF; mode_o = MD_OFF;   end
    endcase
  end

  assign drive_o = dir_a_i ^ dir_b_i;
endmodule

// File: rtl/hb_debounce.sv
module hb_debounce #(
  parameter int DEB_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic flag_i,
  output logic hit_o
);
  localparam int CW = $clog2(DEB_CYC + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (clr_i || !flag_i)     cnt_q <= '0;
    else if (cnt_q != CW'(DEB_CYC)) cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = (cnt_q == CW'(DEB_CYC));

  // a hit needs the flag on the edge just before
  a_r6_hit_after_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> $past(flag_i));
endmodule

// File: rtl/hb_protect.sv
module hb_protect
  import hb_pkg::*;
#(
  parameter int DEB_CYC  = 4,
  parameter int HOLD_CYC = 20
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_en_i,
  input  logic       ocp_i,
  input  logic       drive_i,
  input  logic [1:0] short_i,
  output pstate_e    state_o,
  output logic [1:0] mask_o
);
  localparam int TW = $clog2(HOLD_CYC + 1);

  pstate_e       st_q, st_d;
  logic [TW-1:0] tmr_q;
  logic [1:0]    mask_q;
  logic [1:0]    hit;
  logic          deb_clr;

  assign deb_clr = !run_en_i || (st_q == PS_SCWT);

  for (genvar g = 0; g < 2; g++) begin : g_deb
    hb_debounce #(.DEB_CYC(DEB_CYC)) i_deb (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (deb_clr),
      .flag_i (short_i[g]),
      .hit_o  (hit[g])
    );
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      PS_RUN: begin
        if (|hit)                  st_d = PS_SCWT;
        else if (ocp_i && drive_i) st_d = PS_CLIM;
      end
      PS_CLIM: begin
        if (|hit)              st_d = PS_SCWT;
        else if (tmr_q == '0)  st_d = PS_RUN;
      end
      PS_SCWT:  if (tmr_q == '0) st_d = PS_SCCHK;
      PS_SCCHK: begin
        if (|(hit & mask_q))           st_d = PS_LATCH;
        else if (!(|(short_i & mask_q))) st_d = PS_RUN;
      end
      PS_LATCH: st_d = PS_LATCH;
      default:  st_d = PS_RUN;
    endcase
    if (!run_en_i) st_d = PS_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= PS_RUN;
      tmr_q  <= '0;
      mask_q <= '0;
    end else begin
      st_q <= st_d;
      if (tmr_q != '0) tmr_q <= tmr_q - 1'b1;
      if ((st_d == PS_CLIM && st_q != PS_CLIM) || (st_d == PS_SCWT && st_q != PS_SCWT))
        tmr_q <= TW'(HOLD_CYC - 1);
      if (st_d == PS_SCWT && st_q != PS_SCWT) mask_q <= hit;
      else if (st_d == PS_RUN)               mask_q <= '0;
    end
  end

  assign state_o = st_q;
  assign mask_o  = mask_q;

  a_r10_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_LATCH && run_en_i) |=> st_q == PS_LATCH);
  a_r9_latch_after_retry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == PS_LATCH && $past(st_q) != PS_LATCH) |-> $past(st_q) == PS_SCCHK);
  a_r7_wait_has_leg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == PS_SCWT |-> mask_q != 2'b00);
endmodule

// File: rtl/hb_deadtime.sv
module hb_deadtime
  import hb_pkg::*;
#(
  parameter int DEAD_CYC = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  leg_e req_i,
  output logic hi_o,
  output logic lo_o
);
  localparam int DW = (DEAD_CYC > 0) ? $clog2(DEAD_CYC + 1) : 1;

  leg_e          cur_q;
  logic [DW-1:0] dcnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= LEG_OFF;
      dcnt_q <= '0;
    end else begin
      if (dcnt_q != '0) dcnt_q <= dcnt_q - 1'b1;
      if (req_i != cur_q) begin
        if (cur_q != LEG_OFF) begin
          cur_q  <= LEG_OFF;
          dcnt_q <= DW'(DEAD_CYC);
        end else if (dcnt_q == '0) begin
          cur_q <= req_i;
        end
      end
    end
  end

  assign hi_o = (cur_q == LEG_HI);
  assign lo_o = (cur_q == LEG_LO);

  a_r3_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hi_o && lo_o));
  a_r3_hi_from_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hi_o) |-> !$past(lo_o));
  a_r3_lo_from_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lo_o) |-> !$past(hi_o));
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
  import hb_pkg::*;
#(
  parameter int DEB_CYC  = 4,
  parameter int HOLD_CYC = 20,
  parameter int DEAD_CYC = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_en_i,
  input  logic       dir_a_i,
  input  logic       dir_b_i,
  input  logic       ocp_i,
  input  logic       short_a_i,
  input  logic       short_b_i,
  input  logic       therm_i,
  input  logic       uvlo_i,
  output logic       a_hi_o,
  output logic       a_lo_o,
  output logic       b_hi_o,
  output logic       b_lo_o,
  output logic [2:0] mode_o
);
  leg_e       dec_a, dec_b;
  mode_e      dec_mode;
  logic       dec_drive;
  logic       flt;
  pstate_e    pst;
  logic [1:0] mask;
  leg_e       req [2];
  logic [1:0] hi, lo;
  mode_e      mode;

  assign flt = therm_i || uvlo_i;

  hb_decode i_dec (
    .dir_a_i (dir_a_i),
    .dir_b_i (dir_b_i),
    .leg_a_o (dec_a),
    .leg_b_o (dec_b),
    .mode_o  (dec_mode),
    .drive_o (dec_drive)
  );

  hb_protect #(.DEB_CYC(DEB_CYC), .HOLD_CYC(HOLD_CYC)) i_prot (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_en_i (run_en_i),
    .ocp_i    (ocp_i),
    .drive_i  (dec_drive && !flt),
    .short_i  ({short_b_i, short_a_i}),
    .state_o  (pst),
    .mask_o   (mask)
  );

  always_comb begin
    req[0] = dec_a;
    req[1] = dec_b;
    if (!run_en_i || flt || pst == PS_LATCH) begin
      req[0] = LEG_OFF;
      req[1] = LEG_OFF;
    end else if (pst == PS_CLIM) begin
      req[0] = LEG_LO;
      req[1] = LEG_LO;
    end else if (pst == PS_SCWT) begin
      if (mask[0]) req[0] = LEG_OFF;
      if (mask[1]) req[1] = LEG_OFF;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_leg
    hb_deadtime #(.DEAD_CYC(DEAD_CYC)) i_dt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .req_i  (req[g]),
      .hi_o   (hi[g]),
      .lo_o   (lo[g])
    );
  end

  always_comb begin
    if (!run_en_i)                           mode = MD_STBY;
    else if (pst == PS_LATCH)                mode = MD_LATCH;
    else if (flt)                            mode = MD_OFF;
    else if (pst == PS_SCWT || pst == PS_SCCHK) mode = MD_SCRTY;
    else if (pst == PS_CLIM)                 mode = MD_CLIM;
    else                                     mode = dec_mode;
  end

  assign a_hi_o = hi[0];
  assign a_lo_o = lo[0];
  assign b_hi_o = hi[1];
  assign b_lo_o = lo[1];
  assign mode_o = mode;

  a_r1_standby_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i |=> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o));
  a_r11_fault_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (therm_i || uvlo_i) |=> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o));
  a_r9_latch_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 3'd7) |=> !(a_hi_o || a_lo_o || b_hi_o || b_lo_o));
endmodule

// File: tb/test_hbridge_ctrl.sv
module test_hbridge_ctrl;
  localparam int DEB  = 4;
  localparam int HOLD = 20;
  localparam int DEAD = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 0, da = 0, db = 0, ocp = 0, sa = 0, sb = 0, th = 0, uv = 0;
  logic ahi, alo, bhi, blo;
  logic [2:0] mode;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hbridge_ctrl #(.DEB_CYC(DEB), .HOLD_CYC(HOLD), .DEAD_CYC(DEAD)) i_hbridge_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .run_en_i(en), .dir_a_i(da), .dir_b_i(db),
    .ocp_i(ocp), .short_a_i(sa), .short_b_i(sb), .therm_i(th), .uvlo_i(uv),
    .a_hi_o(ahi), .a_lo_o(alo), .b_hi_o(bhi), .b_lo_o(blo), .mode_o(mode)
  );

  // {en, dir_a, dir_b, a_hi, a_lo, b_hi, b_lo, mode[2:0]}
  localparam logic [9:0] VEC [8] = '{
    {3'b011, 4'b0000, 3'd0},
    {3'b100, 4'b0000, 3'd1},
    {3'b110, 4'b1001, 3'd2},
    {3'b101, 4'b0110, 3'd3},
    {3'b111, 4'b0101, 3'd4},
    {3'b010, 4'b0000, 3'd0},
    {3'b110, 4'b1001, 3'd2},
    {3'b100, 4'b0000, 3'd1}
  };

  localparam logic [6:0] O_FWD = {4'b1001, 3'd2};

  function automatic logic [6:0] obs();
    return {ahi, alo, bhi, blo, mode};
  endfunction

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, logic [6:0] act, logic [6:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic go_fwd();
    en = 1; da = 1; db = 0;
    step(DEAD + 6);
  endtask

  initial begin
    // R12 reset
    step(2);
    chk("R12 in reset", obs(), 7'b0);
    rst_n = 1'b1;
    step(3);
    chk("R12 after reset", obs(), 7'b0);

    // R1/R2 table
    for (int i = 0; i < 8; i++) begin
      {en, da, db} = VEC[i][9:7];
      step(DEAD + 5);
      chk(VEC[i][9] ? "R2 decode" : "R1 standby", obs(), VEC[i][6:0]);
    end

    // R3 dead-time forward -> reverse
    go_fwd();
    da = 0; db = 1;
    begin
      int off_a = 0;
      int ovl = 0;
      for (int k = 0; k < DEAD + 8; k++) begin
        step(1);
        if (!ahi && !alo) off_a++;
        if ((ahi && alo) || (bhi && blo)) ovl++;
      end
      chk("R3 overlap", 7'(ovl), 7'd0);
      chk("R3 dead cycles", 7'(off_a >= DEAD), 7'd1);
    end
    chk("R3 reverse reached", obs(), {4'b0110, 3'd3});

    // R4 current limit in forward
    go_fwd();
    ocp = 1; step(1); ocp = 0;
    step(7);
    chk("R4 slow decay", obs(), {4'b0101, 3'd5});
    step(20);
    chk("R4 resume", obs(), O_FWD);

    // R5 ignored in brake and coast
    da = 1; db = 1; step(DEAD + 6);
    ocp = 1; step(1); ocp = 0; step(3);
    chk("R5 brake", obs(), {4'b0101, 3'd4});
    da = 0; db = 0; step(DEAD + 6);
    ocp = 1; step(1); ocp = 0; step(3);
    chk("R5 coast", obs(), {4'b0000, 3'd1});

    // R6 short pulse below debounce
    go_fwd();
    sa = 1; step(DEB - 1); sa = 0;
    step(4);
    chk("R6 short pulse", obs(), O_FWD);

    // R7 / R8 short on leg B, cleared during hold
    sb = 1; step(DEB + 3);
    chk("R7 leg B open", obs(), {4'b1000, 3'd6});
    sb = 0;
    step(HOLD + DEAD + 6);
    chk("R8 recovered", obs(), O_FWD);

    // R9 persistent short -> latch
    sb = 1;
    step(HOLD + DEB + 8);
    chk("R9 latched", obs(), {4'b0000, 3'd7});
    sb = 0; da = 0; db = 1; ocp = 1; sa = 1;
    step(8);
    ocp = 0; sa = 0;
    step(4);
    chk("R9 latch holds", obs(), {4'b0000, 3'd7});

    // R10 release
    en = 0; step(2);
    chk("R10 release standby", obs(), 7'b0);
    en = 1; da = 1; db = 0;
    step(DEAD + 6);
    chk("R10 drive again", obs(), O_FWD);

    // R11 thermal and undervoltage
    th = 1; step(1);
    chk("R11 thermal off", obs(), {4'b0000, 3'd1});
    th = 0; step(DEAD + 5);
    chk("R11 thermal resume", obs(), O_FWD);
    uv = 1; step(1);
    chk("R11 uvlo off", obs(), {4'b0000, 3'd1});
    uv = 0; step(DEAD + 5);
    chk("R11 uvlo resume", obs(), O_FWD);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule